// File: doc/BRIEF.md
# Quadrant-Configurable Approximate 16x16 Multiplier

This block multiplies two unsigned 16-bit operands and returns a 32-bit product. Each operand is split into a high byte and a low byte. Four pipelined 8x8 sub-multipliers form the four byte-by-byte products, and a final registered adder sums them at weights 2^16, 2^8, 2^8 and 2^0. Each 8x8 unit reduces its partial products in a balanced, registered adder tree.

An 8x8 unit can also be built in a truncated form. That form removes every partial-product bit below a chosen column before reduction. The carries those bits would have produced are lost, and the low product bits read zero. A compile-time configuration picks, for each quadrant, whether its sub-multiplier is exact or uses one of two truncation depths. The high-by-high quadrant is always exact, so error is confined to the lower-weight terms. Accuracy and logic can therefore be traded off per instance, for datapaths such as image filters that tolerate error.

The pipeline accepts one operand pair per cycle. Results emerge six cycles later with a matching valid strobe.

Top module: `amul16_approx`

## Requirements
- R1: While rst_ni is low, and at the first sample after its release, valid_o is 0 and prod_o is 0.
- R2: valid_o is high exactly six clock cycles after a cycle in which valid_i was high, and is low otherwise.
- R3: With CFG=0 every quadrant is exact and prod_o equals a_i*b_i for all operand values.
- R4: prod_o is the sum M1*2^16 + (M2+M3)*2^8 + M4, where M1=a[15:8]*b[15:8], M2=a[15:8]*b[7:0], M3=a[7:0]*b[15:8] and M4=a[7:0]*b[7:0] (each possibly truncated). The 32-bit sum never overflows.
- R5: M1 is exact in every configuration, so operands whose low bytes are both zero yield the exact product for every CFG.
- R6: An exact sub-product keeps all partial products a[i]&b[j]. Truncation variant 1 discards those with i+j<4, and variant 2 discards those with i+j<8, before any addition takes place.
- R7: Quadrant map by CFG. CFG=1 uses variant 1 on M2, M3 and M4. CFG=2 uses variant 1 on M2 and M3 and variant 2 on M4. CFG=3 uses variant 2 on M2, M3 and M4. CFG=4 uses variant 1 on M2 and variant 2 on M3 and M4.
- R8: In a cycle where valid_o is low, prod_o keeps the value it last had.
- R9: Operand pairs presented on consecutive cycles each produce their own result on consecutive cycles.
- R10: A truncated sub-product has its discarded low bits at zero, and its value never exceeds 255*255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand pair strobe |
| a_i | input | 16 | Multiplicand |
| b_i | input | 16 | Multiplier |
| valid_o | output | 1 | Result strobe, six cycles after valid_i |
| prod_o | output | 32 | Product, exact or approximate per CFG |

## Verification
The embedded assertions check three properties on every cycle. They check that truncated sub-products keep their low bits clear and stay within the 8x8 range (R10). They check that the three-term sum cannot carry out of 32 bits (R4). They also check that prod_o holds while valid_o is low (R8).

The numerical value of each product cannot be seen by a property: this covers exactness in CFG=0, the quadrant map and the loss of carries from discarded columns. The six-cycle alignment of results can likewise only be confirmed by the bench. It drives five instances, one per configuration, through single-bit sweeps, corner operands, bubbles and back-to-back random streams, and compares each result with a bitwise sum computed from the requirements.

// File: rtl/amul_pkg.sv
package amul_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT = 2'd0,
    MODE_V1    = 2'd1,
    MODE_V2    = 2'd2
  } amul_mode_e;

  // quad: 0=hi*hi, 1=hi*lo, 2=lo*hi, 3=lo*lo
  function automatic amul_mode_e quad_mode(input int cfg, input int quad);
    amul_mode_e m;
    m = MODE_EXACT;
    if (quad != 0) begin
      case (cfg)
        1: m = MODE_V1;
        2: m = (quad == 3) ? MODE_V2 : MODE_V1;
        3: m = MODE_V2;
        4: m = (quad == 1) ? MODE_V1 : MODE_V2;
        default: m = MODE_EXACT;
      endcase
    end
    return m;
  endfunction

  function automatic int mode_trunc(input amul_mode_e m, input int t1, input int t2);
    int t;
    case (m)
      MODE_V1: t = t1;
      MODE_V2: t = t2;
      default: t = 0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/amul_add_reg.sv
module amul_add_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_o <= '0;
    else         s_o <= a_i + b_i;
  end

endmodule

// File: rtl/amul8_trunc.sv
module amul8_trunc #(
  parameter int OP_W  = 8,
  parameter int TRUNC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o
);

  localparam int PW     = 2 * OP_W;
  localparam int NODES  = 2 * OP_W - 1;
  localparam int LEAF0  = OP_W - 1;
  localparam logic [PW-1:0] KEEP_MASK = {PW{1'b1}} << TRUNC;
  localparam logic [PW-1:0] MAX_P     = PW'((2 ** OP_W - 1) * (2 ** OP_W - 1));

  // heap-ordered tree: node k sums 2k+1 and 2k+2; leaves hold masked rows
  logic [PW-1:0] tree [NODES];

  for (genvar r = 0; r < OP_W; r++) begin : g_row
    logic [PW-1:0] row;
    assign row = (PW'(a_i & {OP_W{b_i[r]}}) << r) & KEEP_MASK;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tree[LEAF0 + r] <= '0;
      else         tree[LEAF0 + r] <= row;
    end
  end

  for (genvar k = 0; k < LEAF0; k++) begin : g_node
    amul_add_reg #(.W(PW)) add_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (tree[2*k+1]),
      .b_i    (tree[2*k+2]),
      .s_o    (tree[k])
    );
  end

  // final carry-propagate register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= tree[0];
  end

  if (TRUNC > 0) begin : g_trunc_chk
    AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_o[TRUNC-1:0] == '0); // R10
  end

  AST_SUB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_o <= MAX_P); // R10

endmodule

// File: rtl/amul_quad_sum.sv
module amul_quad_sum #(
  parameter int OP_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [3:0][2*OP_W-1:0] sub_i,
  output logic [4*OP_W-1:0]      sum_o
);

  localparam int RW = 4 * OP_W;

  logic [RW:0] full;

  assign full = ((RW+1)'(sub_i[0]) << (2*OP_W))
              + ((RW+1)'(sub_i[1]) << OP_W)
              + ((RW+1)'(sub_i[2]) << OP_W)
              +  (RW+1)'(sub_i[3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= full[RW-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> !full[RW]); // R4

endmodule

// File: rtl/amul16_approx.sv
module amul16_approx #(
  parameter int OP_W     = 8,
  parameter int CFG      = 2,
  parameter int TRUNC_V1 = 4,
  parameter int TRUNC_V2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2*OP_W-1:0] a_i,
  input  logic [2*OP_W-1:0] b_i,
  output logic              valid_o,
  output logic [4*OP_W-1:0] prod_o
);

  localparam int SUB_LAT = $clog2(OP_W) + 2;

  logic [OP_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [3:0][2*OP_W-1:0] sub_p;
  logic [SUB_LAT-1:0] vpipe;

  assign {a_hi, a_lo} = a_i;
  assign {b_hi, b_lo} = b_i;

  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam int TR = amul_pkg::mode_trunc(amul_pkg::quad_mode(CFG, q), TRUNC_V1, TRUNC_V2);
    logic [OP_W-1:0] qa, qb;
    assign qa = (q < 2)      ? a_hi : a_lo;
    assign qb = (q % 2 == 0) ? b_hi : b_lo;
    amul8_trunc #(.OP_W(OP_W), .TRUNC(TR)) mul_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (qa),
      .b_i    (qb),
      .prod_o (sub_p[q])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpipe   <= '0;
      valid_o <= 1'b0;
    end else begin
      vpipe   <= {vpipe[SUB_LAT-2:0], valid_i};
      valid_o <= vpipe[SUB_LAT-1];
    end
  end

  amul_quad_sum #(.OP_W(OP_W)) sum_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (vpipe[SUB_LAT-1]),
    .sub_i  (sub_p),
    .sum_o  (prod_o)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(prod_o)); // R8

endmodule

// File: tb/amul16_approx_tb_top.sv
module amul16_approx_tb_top;

  localparam int NCFG = 5;
  localparam int LAT  = 6;
  localparam int HMAX = 8192;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        vld  [NCFG];
  logic [31:0] prod [NCFG];

  always #2.5 clk = ~clk;

  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    amul16_approx #(.OP_W(8), .CFG(c), .TRUNC_V1(4), .TRUNC_V2(8)) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .a_i     (a_i),
      .b_i     (b_i),
      .valid_o (vld[c]),
      .prod_o  (prod[c])
    );
  end

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 1'b0;
  logic [15:0] ha [HMAX];
  logic [15:0] hb [HMAX];
  logic        hv [HMAX];
  logic [31:0] lastp [NCFG];

  // R6 R7: truncation column per config and quadrant (1=hh,2=hl,3=lh,4=ll)
  function automatic int tq(input int cfg, input int q);
    if (q == 1) return 0;
    case (cfg)
      1: return 4;
      2: return (q == 4) ? 8 : 4;
      3: return 8;
      4: return (q == 2) ? 4 : 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] sub8(input logic [7:0] x, input logic [7:0] y, input int t);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (i + j >= t && x[i] && y[j]) r += 32'(1) << (i + j);
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b, input int cfg);
    return (sub8(a[15:8], b[15:8], tq(cfg, 1)) << 16)
         + (sub8(a[15:8], b[7:0],  tq(cfg, 2)) << 8)
         + (sub8(a[7:0],  b[15:8], tq(cfg, 3)) << 8)
         +  sub8(a[7:0],  b[7:0],  tq(cfg, 4));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic ev;
    logic [15:0] ea, eb;
    ev = 1'b0; ea = '0; eb = '0;
    if (n >= LAT) begin
      ev = hv[n-LAT]; ea = ha[n-LAT]; eb = hb[n-LAT];
    end
    for (int c = 0; c < NCFG; c++) begin
      chk(vld[c] == ev, "R2 R9 valid", 32'(vld[c]), 32'(ev));
      if (ev) begin
        logic [31:0] e;
        e = model(ea, eb, c);
        if (c == 0) chk(prod[c] == ea * eb, "R3 R4 exact", prod[c], 32'(ea) * 32'(eb));
        else        chk(prod[c] == e, "R4 R6 R7 approx", prod[c], e);
        if (ea[7:0] == 0 && eb[7:0] == 0)
          chk(prod[c] == 32'(ea) * 32'(eb), "R5 hi exact", prod[c], 32'(ea) * 32'(eb));
        if (c == 3) chk(prod[c][7:0] == 8'h0, "R10 low zero", 32'(prod[c][7:0]), 32'h0);
        lastp[c] = prod[c];
      end else begin
        chk(prod[c] == lastp[c], "R8 hold", prod[c], lastp[c]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    check_outputs();
    if (n < HMAX) begin
      ha[n] = a; hb[n] = b; hv[n] = v;
      n++;
    end
    valid_i = v; a_i = a; b_i = b;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int c = 0; c < NCFG; c++) lastp[c] = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      chk(vld[c] == 1'b0, "R1 valid", 32'(vld[c]), 32'h0);
      chk(prod[c] == 32'h0, "R1 prod", prod[c], 32'h0);
    end
    rst_ni = 1'b1;

    // corner operands back to back (R9)
    begin
      logic [15:0] cv [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h00FF,
                              16'hFF00, 16'h8000, 16'h0100, 16'h7FFF};
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) step(1'b1, cv[i], cv[j]);
    end
    // single-bit sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) step(1'b1, 16'(1) << i, 16'(1) << j);
    // high-byte-only operands (R5)
    for (int i = 0; i < 64; i++) step(1'b1, {8'($urandom), 8'h00}, {8'($urandom), 8'h00});
    // random with bubbles (R8) and streams
    for (int i = 0; i < 1500; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 16'($urandom), 16'($urandom));
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 16'h0, 16'h0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      summary();
      $finish;
    end
  end

endmodule